// File: doc/BRIEF.md
# Interrupt Pin Delivery Engine

This block turns activity on a bank of interrupt input pins into message-signalled interrupts. It receives pin events one per cycle as a pin number and a level. It keeps one pending bit per pin. The redirection table, one 64-bit entry per pin, comes in on a flat input port owned by the surrounding logic. Each entry decides whether its pin is edge- or level-triggered and whether it is masked, and it supplies the fields of the outgoing message.

When a pin is pending, unmasked and free to deliver, the engine builds a 32-bit address and a 32-bit data word from the pin's entry and offers them on a valid/ready write port. When several pins are ready at once, the lowest-numbered pin goes first. Only one message is in flight at a time.

Level-triggered pins follow a remote-in-service handshake. When the engine delivers a level pin, it pulses that pin's bit on a remote-set output. The table owner then records the in-service flag in the entry, and later clears it when the end of service is signalled. While the flag is set, the pin delivers nothing more.

Top module: `ioPinDelivery`

## Requirements
- R1: An event on pin number 0 acts on pin 2. Every other number below the pin count acts on the pin of that number.
- R2: An event whose pin number is at or above the pin count (24 by default) changes nothing and produces no message.
- R3: On a level pin (entry bit 15 = 1), an event with level 1 sets the pending bit and an event with level 0 clears it, whatever the mask. A request that is raised and dropped again while the pin is masked is never delivered.
- R4: On an edge pin (entry bit 15 = 0), an event with level 1 is latched only while the mask bit (entry bit 16) is 0. Clearing the mask later does not deliver it. An event with level 0 has no effect.
- R5: A pending pin whose mask bit is set is not delivered and stays pending. Once the mask is cleared, it is delivered.
- R6: Delivering an edge pin clears its pending bit, so one edge event yields exactly one message.
- R7: Delivering a level pin pulses that pin's bit on `remoteIrrSet` in the cycle its message is loaded. A level pin whose entry shows remote-in-service (bit 14 = 1) sends no message. If it is still pending when that bit clears, it is delivered again.
- R8: The message address is 0xFEE00000 ORed with the entry's destination field (bits 63:48) shifted left by 12 and the destination-mode bit (bit 11) placed at bit 2.
- R9: The message data carries the vector (entry bits 7:0) in bits 7:0, the delivery mode (entry bits 10:8) in bits 10:8 and the trigger bit in bit 15. All other bits are 0.
- R10: Pins that become deliverable in the same cycle are delivered in ascending pin order.
- R11: Only one message is in flight. While `msgValid` is high and `msgReady` is low, the address and data hold still and no other pin is started.
- R12: After reset, no message is valid, no remote-set pulse is driven and no pin is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqValid | input | 1 | A pin event is present this cycle |
| irqNum | input | PIN_W (5) | Pin number of the event |
| irqLevel | input | 1 | Level carried by the event |
| redirTable | input | NUM_PINS*64 | Redirection entries, pin i at bits [64*i+63 : 64*i] |
| msgValid | output | 1 | A message is offered |
| msgReady | input | 1 | The receiver takes the offered message |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |
| remoteIrrSet | output | NUM_PINS | One-cycle request to set a pin's remote-in-service flag |

## Verification
The assertions watch, on every cycle, the parts of the port protocol that hold anywhere. They check that at most one remote-set bit fires, that a remote-set pulse is followed by a valid level-type message, and that a stalled message holds still and blocks any new start. They also check the fixed pattern of the address. Pin rerouting, mask handling for each trigger type, cancellation of a level request, re-delivery after the in-service flag clears and ascending order all depend on event history and table contents. Only the bench's directed and random scenarios can show those, by comparing the collected messages with expected values built from the entries.

// File: rtl/ioPinPkg.sv
package ioPinPkg;
  localparam int ENTRY_W       = 64;
  localparam int IDX_W         = 8;
  localparam int VEC_LSB       = 0;
  localparam int DM_LSB        = 8;
  localparam int DMODE_BIT     = 11;
  localparam int RIRR_BIT      = 14;
  localparam int TRIG_BIT      = 15;
  localparam int MASK_BIT      = 16;
  localparam int DEST_LSB      = 48;
  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;
  localparam int ADDR_DEST_LSB = 12;
  localparam int ADDR_MODE_BIT = 2;
  localparam int DATA_TRIG_BIT = 15;

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] sel;
  } ctrlStrobeT;

  function automatic logic [31:0] buildAddr(input logic [ENTRY_W-1:0] e);
    logic [31:0] a;
    a = MSG_BASE;
    a = a | ({16'b0, e[DEST_LSB +: 16]} << ADDR_DEST_LSB);
    a[ADDR_MODE_BIT] = a[ADDR_MODE_BIT] | e[DMODE_BIT];
    return a;
  endfunction

  function automatic logic [31:0] buildData(input logic [ENTRY_W-1:0] e);
    logic [31:0] d;
    d = '0;
    d[7:0] = e[VEC_LSB +: 8];
    d[10:8] = e[DM_LSB +: 3];
    d[DATA_TRIG_BIT] = e[TRIG_BIT];
    return d;
  endfunction
endpackage

// File: rtl/ioPinDatapath.sv
module ioPinDatapath
  import ioPinPkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        irqValid,
  input  logic [PIN_W-1:0]            irqNum,
  input  logic                        irqLevel,
  input  logic [NUM_PINS*ENTRY_W-1:0] redirTable,
  input  ctrlStrobeT                  strobe,
  output logic [NUM_PINS-1:0]         eligible,
  output logic [NUM_PINS-1:0]         remoteIrrSet,
  output logic [31:0]                 msgAddr,
  output logic [31:0]                 msgData
);
  logic [ENTRY_W-1:0] entry [NUM_PINS];
  logic [NUM_PINS-1:0] pending, pendNext;
  logic [PIN_W-1:0] target;
  logic inRange;
  logic [ENTRY_W-1:0] selEntry;

  assign target  = (irqNum == '0) ? PIN_W'(2) : irqNum;
  assign inRange = irqValid && (int'(target) < NUM_PINS);

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    logic isLevel, masked, hit, setP, lowClr, sendClr, picked;
    assign entry[g] = redirTable[g*ENTRY_W +: ENTRY_W];
    assign isLevel  = entry[g][TRIG_BIT];
    assign masked   = entry[g][MASK_BIT];
    assign hit      = inRange && (int'(target) == g);
    assign picked   = strobe.load && (int'(strobe.sel) == g);
    assign setP     = hit && irqLevel && (isLevel || !masked);
    assign lowClr   = hit && !irqLevel && isLevel;
    assign sendClr  = picked && !isLevel;
    assign pendNext[g] = (pending[g] && !lowClr && !sendClr) || setP;
    assign eligible[g] = pending[g] && !masked && !(isLevel && entry[g][RIRR_BIT]);
    assign remoteIrrSet[g] = picked && isLevel;
  end

  always_comb begin
    selEntry = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (int'(strobe.sel) == i) selEntry = entry[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      msgAddr <= '0;
      msgData <= '0;
    end else begin
      pending <= pendNext;
      if (strobe.load) begin
        msgAddr <= buildAddr(selEntry);
        msgData <= buildData(selEntry);
      end
    end
  end
endmodule

// File: rtl/ioPinControl.sv
module ioPinControl
  import ioPinPkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] eligible,
  input  logic                msgReady,
  output ctrlStrobeT          strobe,
  output logic                msgValid
);
  logic busy;
  logic [IDX_W-1:0] lowest;

  always_comb begin
    lowest = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (eligible[i]) lowest = IDX_W'(i);
  end

  assign strobe.load = !busy && (|eligible);
  assign strobe.sel  = lowest;
  assign msgValid    = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busy <= 1'b0;
    else if (strobe.load) busy <= 1'b1;
    else if (busy && msgReady) busy <= 1'b0;
  end
endmodule

// File: rtl/ioPinDelivery.sv
module ioPinDelivery
  import ioPinPkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        irqValid,
  input  logic [PIN_W-1:0]            irqNum,
  input  logic                        irqLevel,
  input  logic [NUM_PINS*ENTRY_W-1:0] redirTable,
  output logic                        msgValid,
  input  logic                        msgReady,
  output logic [31:0]                 msgAddr,
  output logic [31:0]                 msgData,
  output logic [NUM_PINS-1:0]         remoteIrrSet
);
  ctrlStrobeT strobe;
  logic [NUM_PINS-1:0] eligible;

  ioPinDatapath #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) uData (
    .clk(clk), .rstN(rstN), .irqValid(irqValid), .irqNum(irqNum),
    .irqLevel(irqLevel), .redirTable(redirTable), .strobe(strobe),
    .eligible(eligible), .remoteIrrSet(remoteIrrSet),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  ioPinControl #(.NUM_PINS(NUM_PINS)) uCtrl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .msgReady(msgReady),
    .strobe(strobe), .msgValid(msgValid)
  );
endmodule

// File: rtl/ioPinDeliveryChecker.sv
module ioPinDeliveryChecker #(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                msgValid,
  input logic                msgReady,
  input logic [31:0]         msgAddr,
  input logic [31:0]         msgData,
  input logic [NUM_PINS-1:0] remoteIrrSet
);
  // R7: at most one pin is marked in service per cycle
  a_r7_single_set: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(remoteIrrSet));

  // R7: a remote-set pulse is followed by a level-type message
  a_r7_set_then_msg: assert property (@(posedge clk) disable iff (!rstN)
    (|remoteIrrSet) |=> (msgValid && msgData[15]));

  // R11: a stalled message holds its contents
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));

  // R11: nothing new starts while a message is offered
  a_r11_no_start: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (remoteIrrSet == '0));

  // R8: fixed address pattern
  a_r8_addr_base: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgAddr[31:28] == 4'hF && msgAddr[1:0] == 2'b00));
endmodule

bind ioPinDelivery ioPinDeliveryChecker #(.NUM_PINS(NUM_PINS)) uChk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgReady(msgReady),
  .msgAddr(msgAddr), .msgData(msgData), .remoteIrrSet(remoteIrrSet)
);

// File: tb/ioPinDelivery_test.sv
`timescale 1ns/1ps
module ioPinDelivery_test;
  localparam int N = 24;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqValid = 1'b0;
  logic [PW-1:0] irqNum = '0;
  logic irqLevel = 1'b0;
  logic [N*64-1:0] redirTable;
  logic msgValid, msgReady;
  logic [31:0] msgAddr, msgData;
  logic [N-1:0] remoteIrrSet;

  logic [63:0] tbl [N];
  logic [N-1:0] rirr, eoiMask;
  int readyMode = 0;
  int rxCount = 0;
  logic [31:0] rxAddr [512];
  logic [31:0] rxData [512];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ioPinDelivery #(.NUM_PINS(N)) uut (
    .clk(clk), .rstN(rstN), .irqValid(irqValid), .irqNum(irqNum),
    .irqLevel(irqLevel), .redirTable(redirTable), .msgValid(msgValid),
    .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData),
    .remoteIrrSet(remoteIrrSet)
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      redirTable[i*64 +: 64] = tbl[i];
      redirTable[i*64 + 14]  = rirr[i] & tbl[i][15];
    end
  end

  // table owner: records in-service flags, clears them on end of service
  always @(posedge clk or negedge rstN) begin
    if (!rstN) rirr <= '0;
    else rirr <= (rirr | remoteIrrSet) & ~eoiMask;
  end

  always @(posedge clk) begin
    if (rstN && msgValid && msgReady) begin
      rxAddr[rxCount[8:0]] <= msgAddr;
      rxData[rxCount[8:0]] <= msgData;
      rxCount <= rxCount + 1;
    end
  end

  always @(negedge clk) begin
    if (readyMode == 0) msgReady <= 1'b1;
    else if (readyMode == 1) msgReady <= $urandom % 2;
    else msgReady <= 1'b0;
  end

  function automatic logic [63:0] mkEntry(input logic [7:0] vec, input logic [2:0] dm,
      input logic dmode, input logic lvl, input logic mask, input logic [15:0] dest);
    return {dest, 31'b0, mask, lvl, 1'b0, 2'b0, dmode, dm, vec};
  endfunction

  function automatic logic [31:0] expAddr(input logic [63:0] e);
    return 32'hFEE0_0000 | ({16'b0, e[63:48]} << 12) | ({31'b0, e[11]} << 2);
  endfunction

  function automatic logic [31:0] expData(input logic [63:0] e);
    return {16'b0, e[15], 4'b0, e[10:8], e[7:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input int num, input logic lvl);
    @(negedge clk);
    irqValid = 1'b1; irqNum = PW'(num); irqLevel = lvl;
    @(negedge clk);
    irqValid = 1'b0;
  endtask

  task automatic eoi(input int pin);
    @(negedge clk);
    eoiMask[pin] = 1'b1;
    @(negedge clk);
    eoiMask = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    int base;
    void'($urandom(32'd2024));
    eoiMask = '0;
    for (int i = 0; i < N; i++) tbl[i] = mkEntry(8'(8'h30 + i), 3'd0, 1'b0, 1'b0, 1'b0, 16'(i));
    idle(3);
    // R12: reset state
    check(msgValid == 1'b0, "R12 valid after reset", 32'(msgValid), 32'd0);
    check(remoteIrrSet == '0, "R12 remote-set after reset", 32'(remoteIrrSet), 32'd0);
    rstN = 1'b1;
    idle(5);
    check(rxCount == 0, "R12 no pending after reset", rxCount, 0);

    // Random edge events with random ready (R1, R2, R6, R9)
    readyMode = 1;
    for (int it = 0; it < 40; it++) begin
      int num, pin;
      num = $urandom % 32;
      pin = (num == 0) ? 2 : num;
      base = rxCount;
      fire(num, 1'b1);
      idle(25);
      if (num >= N) check(rxCount == base, "R2 random out of range", rxCount - base, 0);
      else begin
        check(rxCount == base + 1, "R6 random one message", rxCount - base, 1);
        check(rxData[base] == expData(tbl[pin]), "R1 R9 random data", rxData[base], expData(tbl[pin]));
      end
    end
    readyMode = 0;
    idle(5);

    // R8 R9: field placement
    tbl[5] = mkEntry(8'h41, 3'd3, 1'b1, 1'b0, 1'b0, 16'h00AB);
    base = rxCount;
    fire(5, 1'b1); idle(10);
    check(rxAddr[base] == 32'hFEEA_B004, "R8 address", rxAddr[base], 32'hFEEA_B004);
    check(rxData[base] == 32'h0000_0341, "R9 data", rxData[base], 32'h0000_0341);
    check(rxCount == base + 1, "R6 single message", rxCount - base, 1);

    // R1: pin 0 goes to pin 2
    tbl[2] = mkEntry(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0002);
    tbl[0] = mkEntry(8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000);
    base = rxCount;
    fire(0, 1'b1); idle(10);
    check(rxData[base] == 32'h22, "R1 reroute", rxData[base], 32'h22);

    // R2: out of range
    base = rxCount;
    fire(25, 1'b1); fire(31, 1'b1); idle(15);
    check(rxCount == base, "R2 ignored", rxCount - base, 0);

    // R4: masked edge dropped, low level no effect
    tbl[7] = mkEntry(8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0007);
    base = rxCount;
    fire(7, 1'b1); idle(10);
    check(rxCount == base, "R4 masked edge", rxCount - base, 0);
    tbl[7][16] = 1'b0; idle(10);
    check(rxCount == base, "R4 not latched", rxCount - base, 0);
    fire(7, 1'b0); idle(10);
    check(rxCount == base, "R4 edge low", rxCount - base, 0);

    // R5: masked level pin stays pending, delivered on unmask
    tbl[10] = mkEntry(8'h5A, 3'd1, 1'b0, 1'b1, 1'b1, 16'h0010);
    base = rxCount;
    fire(10, 1'b1); idle(10);
    check(rxCount == base, "R5 masked held", rxCount - base, 0);
    tbl[10][16] = 1'b0; idle(10);
    check(rxCount == base + 1, "R5 delivered on unmask", rxCount - base, 1);
    check(rxData[base] == 32'h0000_815A, "R5 R9 level data", rxData[base], 32'h0000_815A);
    check(rirr[10] == 1'b1, "R7 remote set pulse", 32'(rirr[10]), 32'd1);
    fire(10, 1'b0); eoi(10); idle(5);

    // R7: no repeat while in service, repeat after end of service
    tbl[9] = mkEntry(8'h39, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0009);
    base = rxCount;
    fire(9, 1'b1); idle(20);
    check(rxCount == base + 1, "R7 single while in service", rxCount - base, 1);
    check(rxData[base] == 32'h0000_8039, "R7 level data", rxData[base], 32'h0000_8039);
    eoi(9); idle(10);
    check(rxCount == base + 2, "R7 redeliver after clear", rxCount - base, 2);
    fire(9, 1'b0); eoi(9); idle(10);
    check(rxCount == base + 2, "R3 R7 dropped level", rxCount - base, 2);

    // R3: raise and drop while masked
    tbl[11] = mkEntry(8'h3B, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0011);
    base = rxCount;
    fire(11, 1'b1); fire(11, 1'b0); tbl[11][16] = 1'b0; idle(10);
    check(rxCount == base, "R3 cancelled", rxCount - base, 0);

    // R10: ascending order
    tbl[4]  = mkEntry(8'h34, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0004);
    tbl[8]  = mkEntry(8'h38, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0008);
    tbl[12] = mkEntry(8'h3C, 3'd0, 1'b0, 1'b1, 1'b1, 16'h000C);
    base = rxCount;
    fire(12, 1'b1); fire(4, 1'b1); fire(8, 1'b1);
    @(negedge clk);
    tbl[4][16] = 1'b0; tbl[8][16] = 1'b0; tbl[12][16] = 1'b0;
    idle(15);
    check(rxCount == base + 3, "R10 count", rxCount - base, 3);
    check(rxData[base][7:0] == 8'h34, "R10 first", rxData[base], 32'h34);
    check(rxData[base+1][7:0] == 8'h38, "R10 second", rxData[base+1], 32'h38);
    check(rxData[base+2][7:0] == 8'h3C, "R10 third", rxData[base+2], 32'h3C);
    fire(4, 1'b0); fire(8, 1'b0); fire(12, 1'b0);
    eoi(4); eoi(8); eoi(12);

    // R11: stall holds message
    tbl[13] = mkEntry(8'h3D, 3'd2, 1'b0, 1'b0, 1'b0, 16'h1234);
    readyMode = 2; idle(2);
    base = rxCount;
    fire(13, 1'b1); fire(14, 1'b1); idle(5);
    check(msgValid == 1'b1, "R11 valid while stalled", 32'(msgValid), 32'd1);
    check(msgAddr == expAddr(tbl[13]), "R11 R8 stalled addr", msgAddr, expAddr(tbl[13]));
    idle(5);
    check(msgData == expData(tbl[13]), "R11 held data", msgData, expData(tbl[13]));
    check(rxCount == base, "R11 none taken", rxCount - base, 0);
    readyMode = 0; idle(10);
    check(rxCount == base + 2, "R11 drained", rxCount - base, 2);
    check(rxData[base+1] == expData(tbl[14]), "R11 second after stall", rxData[base+1], expData(tbl[14]));

    finishRun();
  end
endmodule